// File: doc/BRIEF.md
# Dual-Bank Configuration Image Manager

This controller looks after two flash banks of equal size, each holding one copy of a configuration image. After reset it checks both copies. A copy counts only when its signature byte is right and both of its checksums match. The controller then makes the copy with the newer generation number the active one. Software fills an image buffer and asks for a commit. The controller then gives the image the next generation number and asks an external checksum engine for the body checksum and then the header checksum, writing each result back into the buffer. Next it has an external flash sequencer erase and program the bank that is not active. The programmed bank becomes active only when both of those steps report success, so a power loss at any point still leaves one intact copy.

The block does no checksum arithmetic and drives no raw flash commands. It orders the requests and keeps the status: which bank is active, its generation, a fatal flag for when neither bank is usable, and a no-space flag for when the last flash update failed.

Top module: `tbs_bank_mgr`

## Requirements
- R1: A bank is valid only if its signature byte equals 0x5A, its stored body checksum equals the computed one and its stored header checksum equals the computed one. A response carries the computed value on `ck_calc` and the stored value on `ck_stored`.
- R2: An invalid bank counts as generation -1 (all ones). Generations are compared as signed 32-bit values. Bank 0 becomes active only when its generation is strictly greater than bank 1's, so a tie selects bank 1.
- R3: If both banks are invalid, `err_fatal` is 1 and `active_valid` is 0. Every later commit request is then ignored: `busy` stays low and no checksum or flash request is made.
- R4: `busy` is 1 from reset until the boot selection is made. The status outputs (`active_valid`, `active_bank`, `active_gen`, `err_fatal`, `err_nospace`) change only on the cycle in which `busy` falls. During reset they read 0, 0, all ones, 0, 0.
- R5: A commit first writes field code 0 (stamp) into the buffer with data equal to `active_gen` + 1. The buffer stores the signature 0x5A alongside that generation.
- R6: The body checksum (kind 0) of the buffer (source code 2) is requested and written back as field code 1 before the header checksum (kind 1) is requested and written back as field code 2. Bank reads use source codes 0 and 1.
- R7: Every flash request targets the bank that is not active. An erase (op 0) comes first, and a program (op 1) is issued only after that erase has reported success.
- R8: When both the erase and the program succeed, the target bank becomes active with the stamped generation and `err_nospace` clears.
- R9: If the erase or the program fails, the active bank and generation stay as they were and `err_nospace` is set to 1.
- R10: If `buf_full` is 0 when a commit is accepted, the controller pulses `buf_reload` with `buf_reload_bank` equal to the active bank. It makes no checksum or flash request and leaves the status unchanged.
- R11: A commit request that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit_req | input | 1 | Commit request, sampled while idle |
| buf_full | input | 1 | Image buffer has been written completely |
| ck_req | output | 1 | Checksum request, held until acknowledged |
| ck_src | output | 2 | Source: 0 bank 0, 1 bank 1, 2 buffer |
| ck_kind | output | 1 | 0 body checksum, 1 header checksum |
| ck_ack | input | 1 | One-cycle response strobe |
| ck_sig | input | 8 | Stored signature byte of the source bank |
| ck_gen | input | 32 | Stored generation of the source bank |
| ck_calc | input | 32 | Computed checksum |
| ck_stored | input | 32 | Checksum stored in the source bank |
| fl_req | output | 1 | Flash request, held until done |
| fl_op | output | 1 | 0 erase, 1 program |
| fl_bank | output | 1 | Bank operated on |
| fl_done | input | 1 | One-cycle completion strobe |
| fl_ok | input | 1 | Operation succeeded, valid with fl_done |
| buf_wr | output | 1 | Buffer header field write strobe |
| buf_field | output | 2 | 0 stamp, 1 body checksum, 2 header checksum |
| buf_data | output | 32 | Field data |
| buf_reload | output | 1 | Discard buffer and reload it from a bank |
| buf_reload_bank | output | 1 | Bank to reload from |
| busy | output | 1 | Boot scan or commit in progress |
| active_valid | output | 1 | An active bank exists |
| active_bank | output | 1 | Index of the active bank |
| active_gen | output | 32 | Generation of the active bank |
| err_fatal | output | 1 | Both banks were invalid at boot |
| err_nospace | output | 1 | Last flash update failed |

## Verification
Boot selection is run on bank pairs that differ in one way each: a clear newer bank 0, equal generations, a bad signature on the newer bank, a broken body checksum, a broken header checksum, a generation whose sign bit is set, and two invalid banks. Between them these patterns separate strict-greater from greater-or-equal, signed from unsigned comparison, and the three validity tests from one another. Commits are tried with a full buffer, a partly written buffer, a failing erase, a failing program and a request that arrives in the middle of another commit. These cases show the difference between promoting the target bank, keeping the old bank and discarding the buffer. A reset after the commits checks that the banks written by those commits are the ones chosen next.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  localparam int WORD_W = 32;
  localparam int SIG_W  = 8;
  localparam int NBANK  = 2;

  typedef logic [WORD_W-1:0] word_t;

  localparam logic [1:0] SRC_BUF  = 2'd2;
  localparam logic       CK_BODY  = 1'b0;
  localparam logic       CK_HDR   = 1'b1;
  localparam logic       FL_ERASE = 1'b0;
  localparam logic       FL_PROG  = 1'b1;
  localparam logic [1:0] FLD_STAMP = 2'd0;
  localparam logic [1:0] FLD_BODY  = 2'd1;
  localparam logic [1:0] FLD_HDR   = 2'd2;

  typedef enum logic [3:0] {
    C_IDLE, C_RELOAD, C_STAMP, C_CKB, C_WRB, C_CKH, C_WRH,
    C_ERASE, C_PROG, C_OK, C_FAIL
  } cstate_e;

  // Tie or older bank 0 selects bank 1.
  function automatic logic prefer_bank1(word_t g0, word_t g1);
    return !($signed(g0) > $signed(g1));
  endfunction

  function automatic word_t bump_gen(word_t g);
    return g + word_t'(1);
  endfunction

  // Invalid copies count as generation -1.
  function automatic word_t eff_gen(logic ok, word_t g);
    return ok ? g : '1;
  endfunction
endpackage

// File: rtl/tbs_scan.sv
module tbs_scan
  import tbs_pkg::*;
#(
  parameter logic [SIG_W-1:0] SIGNATURE = 8'h5A
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ck_ack,
  input  logic [SIG_W-1:0]            ck_sig,
  input  logic [WORD_W-1:0]           ck_gen,
  input  logic [WORD_W-1:0]           ck_calc,
  input  logic [WORD_W-1:0]           ck_stored,
  output logic                        ck_req,
  output logic                        ck_bank,
  output logic                        ck_kind,
  output logic                        scan_done,
  output logic [NBANK-1:0]            bank_ok,
  output logic [NBANK-1:0][WORD_W-1:0] bank_gen
);
  localparam int STEPS  = NBANK * 2;
  localparam int STEP_W = $clog2(STEPS);

  logic [STEP_W-1:0] step;
  logic              running;
  logic              rsp_hit;
  logic              rsp_match;

  assign rsp_hit   = running && ck_ack;
  assign rsp_match = (ck_calc == ck_stored);
  assign ck_req    = running;
  assign ck_bank   = step[1];
  assign ck_kind   = step[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step      <= '0;
      running   <= 1'b1;
      scan_done <= 1'b0;
    end else if (rsp_hit) begin
      step <= step + 1'b1;
      if (step == STEP_W'(STEPS - 1)) begin
        running   <= 1'b0;
        scan_done <= 1'b1;
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic  ok_q;
    word_t gen_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ok_q  <= 1'b0;
        gen_q <= '1;
      end else if (rsp_hit && (step[1] == 1'(b))) begin
        if (step[0] == CK_BODY) begin
          ok_q  <= (ck_sig == SIGNATURE) && rsp_match;
          gen_q <= ck_gen;
        end else begin
          ok_q <= ok_q && rsp_match;
        end
      end
    end
    assign bank_ok[b]  = ok_q;
    assign bank_gen[b] = eff_gen(ok_q, gen_q);
  end
endmodule

// File: rtl/tbs_commit.sv
module tbs_commit
  import tbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              buf_full,
  input  logic              active_bank,
  input  logic [WORD_W-1:0] active_gen,
  input  logic              ck_ack,
  input  logic [WORD_W-1:0] ck_calc,
  input  logic              fl_done,
  input  logic              fl_ok,
  output logic              busy,
  output logic              ck_req,
  output logic              ck_kind,
  output logic              fl_req,
  output logic              fl_op,
  output logic              fl_bank,
  output logic              buf_wr,
  output logic [1:0]        buf_field,
  output logic [WORD_W-1:0] buf_data,
  output logic              buf_reload,
  output logic              buf_reload_bank,
  output logic              fin_ok,
  output logic              fin_fail,
  output logic              target,
  output logic [WORD_W-1:0] new_gen
);
  cstate_e state, nxt;
  word_t   ck_lat;

  always_comb begin
    nxt = state;
    unique case (state)
      C_IDLE:   if (start) nxt = buf_full ? C_STAMP : C_RELOAD;
      C_RELOAD: nxt = C_IDLE;
      C_STAMP:  nxt = C_CKB;
      C_CKB:    if (ck_ack) nxt = C_WRB;
      C_WRB:    nxt = C_CKH;
      C_CKH:    if (ck_ack) nxt = C_WRH;
      C_WRH:    nxt = C_ERASE;
      C_ERASE:  if (fl_done) nxt = fl_ok ? C_PROG : C_FAIL;
      C_PROG:   if (fl_done) nxt = fl_ok ? C_OK : C_FAIL;
      C_OK:     nxt = C_IDLE;
      C_FAIL:   nxt = C_IDLE;
      default:  nxt = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= C_IDLE;
      target  <= 1'b0;
      new_gen <= '0;
      ck_lat  <= '0;
    end else begin
      state <= nxt;
      if (state == C_IDLE && start) begin
        target  <= ~active_bank;
        new_gen <= bump_gen(active_gen);
      end
      if ((state == C_CKB || state == C_CKH) && ck_ack) ck_lat <= ck_calc;
    end
  end

  assign busy            = (state != C_IDLE);
  assign ck_req          = (state == C_CKB) || (state == C_CKH);
  assign ck_kind         = (state == C_CKH) ? CK_HDR : CK_BODY;
  assign fl_req          = (state == C_ERASE) || (state == C_PROG);
  assign fl_op           = (state == C_PROG) ? FL_PROG : FL_ERASE;
  assign fl_bank         = target;
  assign buf_reload      = (state == C_RELOAD);
  assign buf_reload_bank = active_bank;
  assign fin_ok          = (state == C_OK);
  assign fin_fail        = (state == C_FAIL);

  always_comb begin
    buf_wr    = 1'b0;
    buf_field = FLD_STAMP;
    buf_data  = ck_lat;
    unique case (state)
      C_STAMP: begin buf_wr = 1'b1; buf_field = FLD_STAMP; buf_data = new_gen; end
      C_WRB:   begin buf_wr = 1'b1; buf_field = FLD_BODY; end
      C_WRH:   begin buf_wr = 1'b1; buf_field = FLD_HDR; end
      default: ;
    endcase
  end
endmodule

// File: rtl/tbs_bank_mgr.sv
module tbs_bank_mgr
  import tbs_pkg::*;
#(
  parameter logic [SIG_W-1:0] SIGNATURE = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_req,
  input  logic              buf_full,
  output logic              ck_req,
  output logic [1:0]        ck_src,
  output logic              ck_kind,
  input  logic              ck_ack,
  input  logic [SIG_W-1:0]  ck_sig,
  input  logic [WORD_W-1:0] ck_gen,
  input  logic [WORD_W-1:0] ck_calc,
  input  logic [WORD_W-1:0] ck_stored,
  output logic              fl_req,
  output logic              fl_op,
  output logic              fl_bank,
  input  logic              fl_done,
  input  logic              fl_ok,
  output logic              buf_wr,
  output logic [1:0]        buf_field,
  output logic [WORD_W-1:0] buf_data,
  output logic              buf_reload,
  output logic              buf_reload_bank,
  output logic              busy,
  output logic              active_valid,
  output logic              active_bank,
  output logic [WORD_W-1:0] active_gen,
  output logic              err_fatal,
  output logic              err_nospace
);
  logic                         decided;
  logic                         s_req, s_bank, s_kind, s_done;
  logic [NBANK-1:0]             s_ok;
  logic [NBANK-1:0][WORD_W-1:0] s_gen;
  logic                         c_busy, c_req, c_kind, c_ok, c_fail, c_target;
  word_t                        c_gen;
  logic                         commit_go;
  logic                         pick1;

  tbs_scan #(.SIGNATURE(SIGNATURE)) u_scan (
    .clk(clk), .rst_n(rst_n), .ck_ack(ck_ack), .ck_sig(ck_sig),
    .ck_gen(ck_gen), .ck_calc(ck_calc), .ck_stored(ck_stored),
    .ck_req(s_req), .ck_bank(s_bank), .ck_kind(s_kind),
    .scan_done(s_done), .bank_ok(s_ok), .bank_gen(s_gen)
  );

  assign commit_go = commit_req && decided && active_valid && !c_busy;

  tbs_commit u_commit (
    .clk(clk), .rst_n(rst_n), .start(commit_go), .buf_full(buf_full),
    .active_bank(active_bank), .active_gen(active_gen),
    .ck_ack(ck_ack), .ck_calc(ck_calc), .fl_done(fl_done), .fl_ok(fl_ok),
    .busy(c_busy), .ck_req(c_req), .ck_kind(c_kind),
    .fl_req(fl_req), .fl_op(fl_op), .fl_bank(fl_bank),
    .buf_wr(buf_wr), .buf_field(buf_field), .buf_data(buf_data),
    .buf_reload(buf_reload), .buf_reload_bank(buf_reload_bank),
    .fin_ok(c_ok), .fin_fail(c_fail), .target(c_target), .new_gen(c_gen)
  );

  assign ck_req  = decided ? c_req : s_req;
  assign ck_src  = decided ? SRC_BUF : {1'b0, s_bank};
  assign ck_kind = decided ? c_kind : s_kind;
  assign busy    = !decided || c_busy;
  assign pick1   = prefer_bank1(s_gen[0], s_gen[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decided      <= 1'b0;
      active_valid <= 1'b0;
      active_bank  <= 1'b0;
      active_gen   <= '1;
      err_fatal    <= 1'b0;
      err_nospace  <= 1'b0;
    end else if (!decided) begin
      if (s_done) begin
        decided <= 1'b1;
        if (|s_ok) begin
          active_valid <= 1'b1;
          active_bank  <= pick1;
          active_gen   <= pick1 ? s_gen[1] : s_gen[0];
        end else begin
          err_fatal <= 1'b1;
        end
      end
    end else if (c_ok) begin
      active_bank <= c_target;
      active_gen  <= c_gen;
      err_nospace <= 1'b0;
    end else if (c_fail) begin
      err_nospace <= 1'b1;
    end
  end
endmodule

// File: rtl/tbs_bank_mgr_chk.sv
module tbs_bank_mgr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        commit_req,
  input logic        buf_full,
  input logic        ck_req,
  input logic        fl_req,
  input logic        fl_bank,
  input logic        buf_wr,
  input logic [1:0]  buf_field,
  input logic [31:0] buf_data,
  input logic        buf_reload,
  input logic        buf_reload_bank,
  input logic        busy,
  input logic        active_valid,
  input logic        active_bank,
  input logic [31:0] active_gen,
  input logic        err_fatal,
  input logic        err_nospace
);
  // R3
  fatal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_fatal |-> (!active_valid && !ck_req && !fl_req));

  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_bank) |-> $fell(busy));

  // R4
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_gen) |-> $fell(busy));

  // R5
  stamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && buf_field == 2'd0) |-> (buf_data == active_gen + 32'd1));

  // R7
  flash_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |-> (active_valid && fl_bank != active_bank));

  // R8
  gen_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(active_gen) && $past(active_valid)) |-> (active_gen == $past(active_gen) + 32'd1));

  // R9
  nospace_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_nospace) |-> ($stable(active_bank) && $stable(active_gen)));

  // R10
  reload_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && commit_req && !buf_full && active_valid) |=>
      (buf_reload && buf_reload_bank == $past(active_bank) && !ck_req && !fl_req));
endmodule

bind tbs_bank_mgr tbs_bank_mgr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .buf_full(buf_full),
  .ck_req(ck_req), .fl_req(fl_req), .fl_bank(fl_bank),
  .buf_wr(buf_wr), .buf_field(buf_field), .buf_data(buf_data),
  .buf_reload(buf_reload), .buf_reload_bank(buf_reload_bank),
  .busy(busy), .active_valid(active_valid), .active_bank(active_bank),
  .active_gen(active_gen), .err_fatal(err_fatal), .err_nospace(err_nospace)
);

// File: tb/tb_tbs_bank_mgr.sv
module tb_tbs_bank_mgr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic commit_req = 1'b0, buf_full = 1'b0;
  logic ck_req, ck_kind, ck_ack = 1'b0;
  logic [1:0] ck_src;
  logic [7:0] ck_sig = '0;
  logic [31:0] ck_gen = '0, ck_calc = '0, ck_stored = '0;
  logic fl_req, fl_op, fl_bank, fl_done = 1'b0, fl_ok = 1'b0;
  logic buf_wr, buf_reload, buf_reload_bank;
  logic [1:0] buf_field;
  logic [31:0] buf_data;
  logic busy, active_valid, active_bank, err_fatal, err_nospace;
  logic [31:0] active_gen;

  always #5 clk = ~clk;

  tbs_bank_mgr dut (.*);

  // bench-side flash contents and reference status
  logic [7:0]  b_sig[2];
  logic [31:0] b_gen[2];
  logic        b_bb[2], b_hb[2];
  logic        m_valid, m_bank, m_fatal, m_nos;
  logic [31:0] m_gen;
  logic        p_valid, p_bank, p_fatal, p_nos;
  logic [31:0] p_gen;
  logic        fail_erase = 0, fail_prog = 0;
  logic        prev_busy = 1, boot_done = 0, body_seen = 0, erase_ok_seen = 0;
  logic [31:0] stamped = '0;
  int ck_cnt = 0, fl_cnt = 0, n_ck = 0, n_fl = 0, n_reload = 0;
  int vectors = 0, miscompares = 0, cyc = 0;

  function automatic logic [31:0] f_body(logic [31:0] g); return g * 32'd3 + 32'h11; endfunction
  function automatic logic [31:0] f_hdr(logic [31:0] g);  return g ^ 32'h00A5_5A00; endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
    if (!rst_n) begin
      ck_ack = 0; fl_done = 0; ck_cnt = 0; fl_cnt = 0;
      prev_busy = 1; boot_done = 0;
    end else begin
      if (prev_busy && !busy) begin
        m_valid = p_valid; m_bank = p_bank; m_gen = p_gen; m_fatal = p_fatal; m_nos = p_nos;
        boot_done = 1;
      end
      prev_busy = busy;
      chk({active_valid, active_bank, active_gen, err_fatal, err_nospace} ==
          {m_valid, m_bank, m_gen, m_fatal, m_nos}, "R4 R8 R9 status",
          {28'd0, active_valid, active_bank, active_gen, err_fatal, err_nospace},
          {28'd0, m_valid, m_bank, m_gen, m_fatal, m_nos});
      // buffer port
      if (buf_wr) begin
        if (buf_field == 2'd0) begin
          chk(buf_data == m_gen + 32'd1, "R5 stamp", buf_data, m_gen + 32'd1);
          stamped = buf_data; body_seen = 0;
        end else if (buf_field == 2'd1) begin
          chk(buf_data == f_body(stamped), "R6 body write", buf_data, f_body(stamped));
          body_seen = 1;
        end else begin
          chk(body_seen && buf_data == f_hdr(stamped), "R6 header after body",
              {body_seen, buf_data}, {1'b1, f_hdr(stamped)});
        end
      end
      if (buf_reload) begin
        n_reload++;
        chk(buf_reload_bank == m_bank, "R10 reload bank", buf_reload_bank, m_bank);
      end
      // checksum engine
      if (ck_ack) ck_ack = 0;
      else if (ck_req) begin
        if (ck_cnt == 2) begin
          ck_cnt = 0; ck_ack = 1;
          if (boot_done) begin
            n_ck++;
            chk(ck_src == 2'd2, "R6 buffer source", ck_src, 2'd2);
            ck_calc = ck_kind ? f_hdr(stamped) : f_body(stamped);
            ck_stored = ck_calc; ck_sig = 8'h00; ck_gen = '0;
          end else begin
            ck_sig = b_sig[ck_src[0]]; ck_gen = b_gen[ck_src[0]];
            ck_calc = 32'h1234_0000 + {29'd0, ck_src, ck_kind};
            ck_stored = (ck_kind ? b_hb[ck_src[0]] : b_bb[ck_src[0]]) ? ck_calc + 1 : ck_calc;
          end
        end else ck_cnt++;
      end else ck_cnt = 0;
      // flash sequencer
      if (fl_done) fl_done = 0;
      else if (fl_req) begin
        if (fl_cnt == 0) begin
          n_fl++;
          chk(fl_bank == !m_bank, "R7 target bank", fl_bank, !m_bank);
          if (fl_op) chk(erase_ok_seen, "R7 program after erase", erase_ok_seen, 1);
        end
        if (fl_cnt == 3) begin
          fl_cnt = 0; fl_done = 1;
          b_sig[fl_bank] = 8'hFF;
          if (!fl_op) begin
            fl_ok = !fail_erase;
            if (fl_ok) erase_ok_seen = 1; else p_nos = 1;
          end else begin
            fl_ok = !fail_prog;
            if (fl_ok) begin
              b_sig[fl_bank] = 8'h5A; b_gen[fl_bank] = stamped;
              b_bb[fl_bank] = 0; b_hb[fl_bank] = 0;
              p_bank = fl_bank; p_gen = stamped; p_nos = 0;
            end else p_nos = 1;
          end
        end else fl_cnt++;
      end
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!busy) return;
    end
    chk(0, "R4 busy timeout", busy, 0);
  endtask

  task automatic do_reset();
    logic v0, v1;
    logic [31:0] g0, g1;
    @(negedge clk);
    rst_n = 0; commit_req = 0;
    m_valid = 0; m_bank = 0; m_gen = '1; m_fatal = 0; m_nos = 0;
    repeat (2) @(negedge clk);
    chk({busy, active_valid, active_bank, active_gen, err_fatal, err_nospace} ==
        {1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0}, "R4 reset state",
        {busy, active_valid, active_bank, active_gen, err_fatal, err_nospace},
        {1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0});
    v0 = b_sig[0] == 8'h5A && !b_bb[0] && !b_hb[0];
    v1 = b_sig[1] == 8'h5A && !b_bb[1] && !b_hb[1];
    g0 = v0 ? b_gen[0] : 32'hFFFF_FFFF;
    g1 = v1 ? b_gen[1] : 32'hFFFF_FFFF;
    p_nos = 0;
    if (!v0 && !v1) begin
      p_valid = 0; p_fatal = 1; p_bank = 0; p_gen = '1;
    end else begin
      p_valid = 1; p_fatal = 0;
      if ($signed(g0) > $signed(g1)) begin p_bank = 0; p_gen = g0; end
      else begin p_bank = 1; p_gen = g1; end
    end
    rst_n = 1;
    wait_idle();
  endtask

  task automatic boot(input logic [7:0] s0, input logic [31:0] g0, input logic bb0, input logic hb0,
                      input logic [7:0] s1, input logic [31:0] g1, input logic bb1, input logic hb1);
    b_sig[0] = s0; b_gen[0] = g0; b_bb[0] = bb0; b_hb[0] = hb0;
    b_sig[1] = s1; b_gen[1] = g1; b_bb[1] = bb1; b_hb[1] = hb1;
    do_reset();
  endtask

  task automatic commit(input logic full, input logic fe, input logic fp);
    fail_erase = fe; fail_prog = fp; erase_ok_seen = 0;
    @(negedge clk);
    commit_req = 1; buf_full = full;
    @(negedge clk);
    commit_req = 0;
    wait_idle();
  endtask

  task automatic expect_active(input logic bank, input logic [31:0] gen, input string tag);
    chk(active_valid && active_bank == bank && active_gen == gen, tag,
        {active_valid, active_bank, active_gen}, {1'b1, bank, gen});
  endtask

  initial begin
    int fl0, ck0, rl0;
    boot(8'h5A, 32'd10, 0, 0, 8'h5A, 32'd9, 0, 0);
    expect_active(0, 32'd10, "R2 newer bank0");
    commit(1, 0, 0);
    expect_active(1, 32'd11, "R8 commit to bank1");
    commit(1, 0, 0);
    expect_active(0, 32'd12, "R8 commit to bank0");
    fl0 = n_fl; ck0 = n_ck; rl0 = n_reload;
    commit(0, 0, 0);
    chk(n_reload - rl0 == 1 && n_fl == fl0 && n_ck == ck0, "R10 discard no flash",
        {n_reload - rl0, n_fl - fl0, n_ck - ck0}, {32'd1, 32'd0, 32'd0});
    expect_active(0, 32'd12, "R10 status kept");
    fl0 = n_fl;
    commit(1, 1, 0);
    expect_active(0, 32'd12, "R9 erase fail keeps bank");
    chk(err_nospace && n_fl - fl0 == 1, "R9 erase fail nospace no program",
        {err_nospace, n_fl - fl0}, {1'b1, 32'd1});
    commit(1, 0, 1);
    expect_active(0, 32'd12, "R9 program fail keeps bank");
    chk(err_nospace == 1, "R9 nospace after program fail", err_nospace, 1);
    commit(1, 0, 0);
    expect_active(1, 32'd13, "R8 success after failures");
    chk(err_nospace == 0, "R8 nospace cleared", err_nospace, 0);
    // R11: second request during an ongoing commit
    fail_erase = 0; fail_prog = 0; erase_ok_seen = 0;
    @(negedge clk); commit_req = 1; buf_full = 1;
    @(negedge clk); commit_req = 0;
    repeat (3) @(negedge clk);
    commit_req = 1;
    @(negedge clk); commit_req = 0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(!busy, "R11 no second commit", busy, 0);
    expect_active(0, 32'd14, "R11 single generation step");
    do_reset();
    expect_active(0, 32'd14, "R2 reboot picks committed image");
    boot(8'h5A, 32'd4, 0, 0, 8'h5A, 32'd4, 0, 0);
    expect_active(1, 32'd4, "R2 tie picks bank1");
    boot(8'h5B, 32'd50, 0, 0, 8'h5A, 32'd2, 0, 0);
    expect_active(1, 32'd2, "R1 bad signature");
    boot(8'h5A, 32'd3, 0, 0, 8'h5A, 32'd9, 1, 0);
    expect_active(0, 32'd3, "R1 bad body checksum");
    boot(8'h5A, 32'd3, 0, 0, 8'h5A, 32'd9, 0, 1);
    expect_active(0, 32'd3, "R1 bad header checksum");
    boot(8'h5A, 32'd7, 0, 0, 8'h5A, 32'h8000_0005, 0, 0);
    expect_active(0, 32'd7, "R2 signed compare");
    boot(8'h00, 32'd7, 0, 0, 8'h5A, 32'd8, 1, 1);
    chk(err_fatal && !active_valid, "R3 fatal flag", {err_fatal, active_valid}, {1'b1, 1'b0});
    fl0 = n_fl; ck0 = n_ck; rl0 = n_reload;
    @(negedge clk); commit_req = 1; buf_full = 1;
    @(negedge clk); commit_req = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!busy, "R3 commit ignored busy", busy, 0);
    end
    chk(n_fl == fl0 && n_ck == ck0 && n_reload == rl0, "R3 no requests",
        {n_fl - fl0, n_ck - ck0}, 0);
    finish_run();
  end
endmodule